// File: doc/BRIEF.md
# Masked Interrupt Dispatcher with Vector Mapping

This block decides which interrupt source enters service and which parent interrupt line it raises. It holds a per-source mask register, where a set bit blocks the source, and a per-source in-service register. An input latch upstream supplies the vector of pending sources together with assert and deassert events. Each event carries a line mask that says which sources it concerns. On every event the block services only the lowest-numbered eligible source. A per-source table of 8-bit entries steers that source to one output in a bank of registered parent interrupt lines.

Writing the mask register runs the same evaluation again for the bits that changed. Bits being unmasked are treated as an assert event over those bits, using the pending vector presented with the write. Bits being masked are treated as a deassert event over those bits. A status vector shows the in-service sources that are not masked. Register bus decoding and edge detection are handled elsewhere: this block sees only the decoded write strobes and the events that are already qualified.

Top module: `intr_route_dispatch`

## Requirements
- R1: After reset the mask register is all ones, the in-service register is zero, every steering table entry is zero, and all parent lines and all status bits are low.
- R2: On an assert event, the eligible set is `evt_lines & pend_vec & ~mask`. If that set is non-empty, its lowest-numbered bit becomes in-service and the parent line selected by that source's table entry goes high. Both take effect at the clock edge that samples the event.
- R3: An assert event whose eligible set is empty changes neither the in-service register nor any parent line.
- R4: On a deassert event, the eligible set is `evt_lines & in_service`. Its lowest-numbered bit leaves service and the parent line selected by that source's entry goes low, even when other in-service sources steer to the same line.
- R5: A mask write replaces the mask with `mask_wdata`. The bits that go from 1 to 0 are evaluated as an assert event over those bits, using `pend_vec`.
- R6: In the same mask write, the bits that go from 0 to 1 are evaluated as a deassert event over those bits, using the in-service register.
- R7: `status` always equals the in-service register ANDed with the inverted mask.
- R8: A table write stores `vec_wr_data` as the entry for source `vec_wr_idx`, and the stored value is the index of the parent line for that source. An entry at or above the number of parent lines drives no line, but the source still enters or leaves service.
- R9: Only one operation runs per cycle, in the priority order mask write, then assert, then deassert. The lower-priority events of that cycle are dropped. When one mask write both clears and sets the same parent line, the line ends high.
- R10: At most one source enters service per cycle, and at most one source leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| evt_assert | input | 1 | Assert event strobe |
| evt_deassert | input | 1 | Deassert event strobe |
| evt_lines | input | NSRC | Sources that the event concerns |
| pend_vec | input | NSRC | Pending vector from the input latch |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | NSRC | New mask value, where 1 means masked |
| vec_wr | input | 1 | Steering table write strobe |
| vec_wr_idx | input | $clog2(NSRC) | Source whose entry is written |
| vec_wr_data | input | VW | Parent line index to store |
| parent_irq | output | NOUT | Registered parent interrupt lines |
| status | output | NSRC | In-service sources that are not masked |

## Verification
The assert path is driven with line masks that select one source, several sources, and only masked sources. This separates lowest-bit selection from mask filtering and from the empty-set case. The deassert path uses a line mask that covers several in-service sources that share one parent line, which shows that only the lowest source is released and that the shared line drops anyway. Mask writes that unmask and mask bits in the same write, with the old and new sources steered to the same line, show that both halves run and that the set takes precedence. A steering entry beyond the bank, together with colliding assert and deassert strobes, shows that service state is kept apart from line driving and confirms the priority order.

// File: rtl/intr_disp_pkg.sv
package intr_disp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE     = 2'd0,
    OP_MASK     = 2'd1,
    OP_ASSERT   = 2'd2,
    OP_DEASSERT = 2'd3
  } disp_op_e;

  // Pick the single operation of a cycle: mask write beats assert beats deassert.
  function automatic disp_op_e pick_op(input logic m_wr, input logic a, input logic d);
    if (m_wr)   return OP_MASK;
    else if (a) return OP_ASSERT;
    else if (d) return OP_DEASSERT;
    else        return OP_IDLE;
  endfunction

endpackage

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int W  = 64,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_in,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);

  // Scan from the top down so the lowest set bit is the last one written.
  always_comb begin
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_in[i]) begin
        found  = 1'b1;
        idx    = IW'(i);
        onehot = W'(1) << i;
      end
    end
  end

endmodule

// File: rtl/intr_vec_table.sv
module intr_vec_table #(
  parameter int NSRC = 64,
  parameter int VW   = 8,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [VW-1:0] wr_data,
  input  logic [IW-1:0] rd_a_idx,
  output logic [VW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [VW-1:0] rd_b_data
);

  logic [VW-1:0] entry_q [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        entry_q[g] <= wr_data;
    end
  end

  assign rd_a_data = entry_q[rd_a_idx];
  assign rd_b_data = entry_q[rd_b_idx];

endmodule

// File: rtl/intr_out_bank.sv
module intr_out_bank #(
  parameter int NOUT = 16,
  parameter int VW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [VW-1:0]   set_sel,
  input  logic            clr_en,
  input  logic [VW-1:0]   clr_sel,
  output logic [NOUT-1:0] lines_q
);

  // Clear is applied before set, so a line that gets both ends high.
  for (genvar g = 0; g < NOUT; g++) begin : g_line
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_sel == VW'(g));
    assign hit_clr = clr_en && (clr_sel == VW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        lines_q[g] <= 1'b0;
      else if (hit_set)
        lines_q[g] <= 1'b1;
      else if (hit_clr)
        lines_q[g] <= 1'b0;
    end
  end

  // R8
  out_of_range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && (int'(set_sel) >= NOUT) && !clr_en) |=> $stable(lines_q));

endmodule

// File: rtl/intr_route_dispatch.sv
module intr_route_dispatch
  import intr_disp_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NOUT = 16,
  parameter int VW   = 8,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_assert,
  input  logic            evt_deassert,
  input  logic [NSRC-1:0] evt_lines,
  input  logic [NSRC-1:0] pend_vec,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            vec_wr,
  input  logic [IW-1:0]   vec_wr_idx,
  input  logic [VW-1:0]   vec_wr_data,
  output logic [NOUT-1:0] parent_irq,
  output logic [NSRC-1:0] status
);

  function automatic logic [NSRC-1:0] raise_set(input logic [NSRC-1:0] lines,
      input logic [NSRC-1:0] pend, input logic [NSRC-1:0] msk);
    return lines & pend & ~msk;
  endfunction

  function automatic logic [NSRC-1:0] drop_set(input logic [NSRC-1:0] lines,
      input logic [NSRC-1:0] svc);
    return lines & svc;
  endfunction

  logic [NSRC-1:0] mask_q, insvc_q;
  logic [NSRC-1:0] set_cand, clr_cand;
  logic [NSRC-1:0] set_onehot, clr_onehot;
  logic            set_found, clr_found;
  logic [IW-1:0]   set_idx, clr_idx;
  logic [VW-1:0]   set_vec, clr_vec;
  disp_op_e        op;

  assign op = pick_op(mask_wr, evt_assert, evt_deassert);

  always_comb begin
    set_cand = '0;
    clr_cand = '0;
    case (op)
      OP_MASK: begin
        // Bits going 1->0 are unmasked under the new value; bits going 0->1 are masked.
        set_cand = raise_set(mask_q & ~mask_wdata, pend_vec, mask_wdata);
        clr_cand = drop_set(~mask_q & mask_wdata, insvc_q);
      end
      OP_ASSERT:   set_cand = raise_set(evt_lines, pend_vec, mask_q);
      OP_DEASSERT: clr_cand = drop_set(evt_lines, insvc_q);
      default: ;
    endcase
  end

  intr_prio_enc #(.W(NSRC)) u_set_enc (
    .vec_in(set_cand), .found(set_found), .idx(set_idx), .onehot(set_onehot)
  );

  intr_prio_enc #(.W(NSRC)) u_clr_enc (
    .vec_in(clr_cand), .found(clr_found), .idx(clr_idx), .onehot(clr_onehot)
  );

  intr_vec_table #(.NSRC(NSRC), .VW(VW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(vec_wr), .wr_idx(vec_wr_idx), .wr_data(vec_wr_data),
    .rd_a_idx(set_idx), .rd_a_data(set_vec),
    .rd_b_idx(clr_idx), .rd_b_data(clr_vec)
  );

  intr_out_bank #(.NOUT(NOUT), .VW(VW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_found), .set_sel(set_vec),
    .clr_en(clr_found), .clr_sel(clr_vec),
    .lines_q(parent_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      insvc_q <= '0;
    end else begin
      if (op == OP_MASK) mask_q <= mask_wdata;
      insvc_q <= (insvc_q & ~clr_onehot) | set_onehot;
    end
  end

  assign status = insvc_q & ~mask_q;

  logic past_ok_q;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // R10
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> ($countones(insvc_q & ~$past(insvc_q)) <= 1));

  // R10
  single_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> ($countones($past(insvc_q) & ~insvc_q) <= 1));

  // R2
  entry_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> ((insvc_q & ~$past(insvc_q) & mask_q) == '0));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> ($stable(insvc_q) && $stable(mask_q) && $stable(parent_irq)));

endmodule

// File: tb/intr_route_dispatch_tb_top.sv
`timescale 1ns/100ps
module intr_route_dispatch_tb_top;
  localparam int NSRC = 64;
  localparam int NOUT = 16;
  localparam int VW   = 8;
  localparam int IW   = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_assert = 0, evt_deassert = 0, mask_wr = 0, vec_wr = 0;
  logic [NSRC-1:0] evt_lines = '0, pend_vec = '0, mask_wdata = '0;
  logic [IW-1:0] vec_wr_idx = '0;
  logic [VW-1:0] vec_wr_data = '0;
  logic [NOUT-1:0] parent_irq;
  logic [NSRC-1:0] status;

  always #2.5 clk = ~clk;

  intr_route_dispatch #(.NSRC(NSRC), .NOUT(NOUT), .VW(VW)) dut_i (.*);

  typedef struct packed {
    logic [NOUT-1:0] lines;
    logic [NSRC-1:0] stat;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // Reference state
  logic [NSRC-1:0] m_mask, m_svc;
  logic [NOUT-1:0] m_lines;
  int m_tab [NSRC];

  function automatic int first_one(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [NSRC-1:0] bit_of(input int i);
    return NSRC'(1) << i;
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.lines = m_lines;
    e.stat  = m_svc & ~m_mask;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic step(input bit a, input bit d, input bit mw, input logic [NSRC-1:0] mdata,
                      input logic [NSRC-1:0] lines, input logic [NSRC-1:0] pend, input string tag);
    logic [NSRC-1:0] sc, cc;
    int si, ci;
    @(negedge clk);
    evt_assert = a; evt_deassert = d; mask_wr = mw; mask_wdata = mdata;
    evt_lines = lines; pend_vec = pend; vec_wr = 0;
    sc = '0; cc = '0;
    if (mw) begin
      sc = (m_mask & ~mdata) & pend;
      cc = (~m_mask & mdata) & m_svc;
      m_mask = mdata;
    end else if (a) sc = lines & pend & ~m_mask;
    else if (d)     cc = lines & m_svc;
    si = first_one(sc);
    ci = first_one(cc);
    if (ci >= 0) begin
      m_svc[ci] = 1'b0;
      if (m_tab[ci] < NOUT) m_lines[m_tab[ci]] = 1'b0;
    end
    if (si >= 0) begin
      m_svc[si] = 1'b1;
      if (m_tab[si] < NOUT) m_lines[m_tab[si]] = 1'b1;
    end
    push_exp(tag);
  endtask

  task automatic vwrite(input int idx, input int val);
    @(negedge clk);
    evt_assert = 0; evt_deassert = 0; mask_wr = 0;
    vec_wr = 1; vec_wr_idx = IW'(idx); vec_wr_data = VW'(val);
    m_tab[idx] = val;
    push_exp("R8 table write leaves outputs");
  endtask

  // Monitor: compare just after each active edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (parent_irq !== e.lines || status !== e.stat) begin
        failures++;
        $display("FAIL %s: lines=%h status=%h expected lines=%h status=%h",
                 t, parent_irq, status, e.lines, e.stat);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NSRC-1:0] w;
    m_mask = '1; m_svc = '0; m_lines = '0;
    for (int i = 0; i < NSRC; i++) m_tab[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (parent_irq !== '0 || status !== '0) begin
      failures++;
      $display("FAIL R1 reset: lines=%h status=%h expected lines=0 status=0", parent_irq, status);
    end

    vwrite(3, 5); vwrite(10, 5); vwrite(7, 2); vwrite(20, 200);
    vwrite(40, 15); vwrite(41, 2);

    step(1, 0, 0, '0, bit_of(3), bit_of(3), "R3 assert while all masked");
    w = ~(bit_of(0) | bit_of(3) | bit_of(7) | bit_of(10) | bit_of(20) | bit_of(40));
    step(0, 0, 1, w, '0, bit_of(7) | bit_of(10), "R5 unmask raises lowest pending");
    step(1, 0, 0, '0, bit_of(3) | bit_of(10), bit_of(3) | bit_of(10), "R2 assert picks lowest");
    step(1, 0, 0, '0, bit_of(10), bit_of(10), "R2 assert shared line");
    step(1, 0, 0, '0, bit_of(40), '0, "R3 assert with nothing pending");
    step(1, 0, 0, '0, bit_of(20), bit_of(20), "R8 out-of-range entry still in service");
    step(0, 1, 0, '0, bit_of(3) | bit_of(10), '0, "R4 deassert lowest drops shared line");
    w = (m_mask | bit_of(7) | bit_of(10)) & ~bit_of(41);
    step(0, 0, 1, w, '0, bit_of(41), "R6 R9 R7 mask and unmask same line");
    step(1, 1, 0, '0, bit_of(40) | bit_of(20), bit_of(40), "R9 assert beats deassert");
    step(1, 0, 1, m_mask, bit_of(0), bit_of(0), "R9 mask write beats assert");
    step(0, 1, 0, '0, '1, '0, "R4 R10 deassert all lines releases one");
    step(0, 1, 0, '0, '1, '0, "R10 second release");
    step(0, 0, 0, '0, '0, '0, "R3 idle");
    step(0, 0, 1, '1, '0, '0, "R6 R7 mask all");
    step(0, 0, 0, '0, '0, '0, "R7 idle after mask");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule